// File: doc/BRIEF.md
# Lookahead Instruction Fetch Buffer

This block is a six-entry instruction queue between instruction memory and the decode stage. It keeps requesting sequential words from memory for as long as the queue has room for them. Each word that memory returns is examined for branches before it is stored, so branch handling never waits for decode. The block computes the branch target and decides how the branch is handled. Jumps, and conditional branches whose outcome is already known, are removed from the stream and steer fetch directly, so they take no issue slot. Conditional branches with an unknown outcome are queued with a static prediction. Backward offsets are predicted taken, and their target words are fetched at once so that they land right behind the branch in the queue.

Every fetch request carries a path tag. Whenever fetch changes course, the tag advances, and any returning word whose tag no longer matches is dropped. When the execution stage reports that a prediction was wrong, it drives a redirect. The queue empties, nothing issues in that cycle, and fetch restarts at the corrected address. Memory must return words in request order and must answer every request.

Top module: `lookahead_fetch_buffer`

## Requirements
- R1: In the first cycle after synchronous reset, the queue is empty and `issue_valid_o` is low. No requests are in flight, `fetch_tag_o` is 0, and `fetch_req_o` is high with `fetch_addr_o` equal to `RESET_PC` (default 0).
- R2: The number of queued words plus the number of requests still awaiting a response never exceeds DEPTH (6). `fetch_req_o` is raised only when that sum is below DEPTH. If decode stalls, fetch therefore stops once six words are queued.
- R3: Words that are not branches issue in program order. Each carries the byte address it was fetched from in `issue_pc_o`, and consecutive fetches step by 4.
- R4: The opcode is bits 31:26 of a word. Opcode 6'h12 is an unconditional jump and 6'h10 is a conditional branch. For both, bits 25:0 hold a signed word offset, and the target is the branch address plus four times that offset.
- R5: An unconditional jump is never issued. The word that issues after the words before it comes from the jump target.
- R6: A conditional branch that arrives while `cond_known_i` is high is never issued. Fetch continues at the target when `cond_taken_i` is high, and at the next sequential word otherwise.
- R7: A conditional branch that arrives while `cond_known_i` is low is issued once. `issue_pred_o` equals its offset sign bit (bit 25). When the prediction is taken, the next word issued is the target; when it is not taken, the next word is the branch address plus 4.
- R8: A word leaves the queue only in a cycle where `issue_valid_o` and `issue_ready_i` are both high. While decode holds off, the offered word and its address stay unchanged.
- R9: In a cycle where `redirect_valid_i` is high, `issue_valid_o` is low and no word is accepted. The queue is empty in the next cycle, and fetch resumes at `redirect_pc_i`.
- R10: A returned word whose `rsp_tag_i` differs from the current `fetch_tag_o` is discarded. It is never queued and does not steer fetch.
- R11: Every change of fetch path (a redirect, a folded taken branch, or a predicted-taken branch) changes `fetch_tag_o` for the requests that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req_o | output | 1 | Fetch request to instruction memory, accepted every cycle it is high |
| fetch_addr_o | output | 32 | Byte address of the requested word |
| fetch_tag_o | output | TAG_W | Path tag attached to the request |
| rsp_valid_i | input | 1 | A word is returned this cycle |
| rsp_data_i | input | 32 | Returned instruction word |
| rsp_tag_i | input | TAG_W | Tag of the request being answered |
| cond_known_i | input | 1 | The outcome of an arriving conditional branch is already resolved |
| cond_taken_i | input | 1 | Resolved outcome, used when `cond_known_i` is high |
| issue_valid_o | output | 1 | The head word is offered to decode |
| issue_ready_i | input | 1 | Decode accepts the offered word |
| issue_instr_o | output | 32 | Offered instruction word |
| issue_pc_o | output | 32 | Address of the offered word |
| issue_pred_o | output | 1 | Offered word is a branch predicted taken |
| redirect_valid_i | input | 1 | Misprediction: flush the queue and restart fetch |
| redirect_pc_i | input | 32 | Address of the corrected path |

## Verification
Some properties are checked in every cycle. These are the bound on queued plus in-flight words, the fetch-gating rule, and the hold of an offered word under backpressure. The checks also cover the empty queue and new fetch address after a redirect, the tag change on a redirect, the fact that a mismatched response never adds a word, and the absence of jumps from the issue port. Other behaviour only the bench scenarios can show. These include the order in which words arrive at decode after folding and prediction, the path taken by resolved conditional branches, and the resumption at the corrected address after stale words in flight are dropped. The bench sweeps memory latency, decode backpressure pattern and branch-resolution mode, and compares every issued word against a walk of the program built from the requirements.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_JUMP  = 6'h12;
    localparam logic [5:0] OPC_BCOND = 6'h10;

    typedef enum logic [1:0] {
        BK_NONE,
        BK_JUMP,
        BK_COND
    } br_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] instr;
        logic            pred_taken;
    } slot_t;

    function automatic br_kind_e classify(input logic [XLEN-1:0] w);
        br_kind_e k;
        if (w[31:26] == OPC_JUMP)       k = BK_JUMP;
        else if (w[31:26] == OPC_BCOND) k = BK_COND;
        else                            k = BK_NONE;
        return k;
    endfunction

    // Target = branch address + 4 * signed 26-bit word offset
    function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] pc,
                                                      input logic [XLEN-1:0] w);
        return pc + {{4{w[25]}}, w[25:0], 2'b00};
    endfunction

endpackage

// File: rtl/lfb_branch_scan.sv
module lfb_branch_scan
    import lfb_pkg::*;
(
    input  logic [XLEN-1:0] word_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            cond_known_i,
    input  logic            cond_taken_i,
    output logic            keep_o,
    output logic            pred_taken_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o
);

    br_kind_e kind;
    logic     backward;

    always_comb begin
        kind          = classify(word_i);
        backward      = word_i[25];
        redirect_pc_o = branch_target(pc_i, word_i);
        keep_o        = 1'b1;
        pred_taken_o  = 1'b0;
        redirect_o    = 1'b0;
        unique case (kind)
            BK_JUMP: begin
                // folded: steer fetch, never occupy a slot
                keep_o     = 1'b0;
                redirect_o = 1'b1;
            end
            BK_COND: begin
                if (cond_known_i) begin
                    keep_o     = 1'b0;
                    redirect_o = cond_taken_i;
                end else begin
                    // static rule: backward taken, forward not taken
                    pred_taken_o = backward;
                    redirect_o   = backward;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lfb_slot_queue.sv
module lfb_slot_queue
    import lfb_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic flush_i,
    input  logic push_i,
    input  slot_t push_data_i,
    input  logic pop_i,
    output slot_t head_o,
    output logic head_valid_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    slot_t            rd_view [DEPTH];

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        slot_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (push_i && !flush_i && wr_ptr == PTR_W'(s)) begin
                q <= push_data_i;
            end
        end
        assign rd_view[s] = q;
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) wr_ptr <= step_ptr(wr_ptr);
            if (pop_i)  rd_ptr <= step_ptr(rd_ptr);
            unique case ({push_i, pop_i})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_o       = rd_view[rd_ptr];
    assign head_valid_o = (count != '0);
    assign count_o      = count;

endmodule

// File: rtl/lfb_fetch_ctl.sv
module lfb_fetch_ctl
    import lfb_pkg::*;
#(
    parameter int              DEPTH    = 6,
    parameter int              TAG_W    = 3,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(DEPTH+1)-1:0]  occupancy_i,
    input  logic                        redir_i,
    input  logic [XLEN-1:0]             redir_pc_i,
    input  logic                        rsp_valid_i,
    input  logic                        rsp_accept_i,
    output logic                        fetch_req_o,
    output logic [XLEN-1:0]             fetch_addr_o,
    output logic [TAG_W-1:0]            fetch_tag_o,
    output logic [XLEN-1:0]             resp_pc_o,
    output logic [$clog2(DEPTH+1)-1:0]  inflight_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [XLEN-1:0]  fetch_pc, resp_pc;
    logic [TAG_W-1:0] tag;
    logic [CNT_W-1:0] inflight;
    logic [CNT_W:0]   committed;
    logic             room;

    // slots are reserved at request time, so every answer has a place
    assign committed   = {1'b0, occupancy_i} + {1'b0, inflight};
    assign room        = committed < (CNT_W + 1)'(DEPTH);
    assign fetch_req_o = room && !redir_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_pc <= RESET_PC;
            resp_pc  <= RESET_PC;
            tag      <= '0;
            inflight <= '0;
        end else begin
            unique case ({fetch_req_o, rsp_valid_i})
                2'b10:   inflight <= inflight + 1'b1;
                2'b01:   inflight <= inflight - 1'b1;
                default: inflight <= inflight;
            endcase
            if (redir_i) begin
                fetch_pc <= redir_pc_i;
                resp_pc  <= redir_pc_i;
                tag      <= tag + 1'b1;
            end else begin
                if (fetch_req_o)  fetch_pc <= fetch_pc + XLEN'(4);
                if (rsp_accept_i) resp_pc  <= resp_pc + XLEN'(4);
            end
        end
    end

    assign fetch_addr_o = fetch_pc;
    assign fetch_tag_o  = tag;
    assign resp_pc_o    = resp_pc;
    assign inflight_o   = inflight;

endmodule

// File: rtl/lookahead_fetch_buffer.sv
module lookahead_fetch_buffer
    import lfb_pkg::*;
#(
    parameter int              DEPTH    = 6,
    parameter int              TAG_W    = 3,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    output logic             fetch_req_o,
    output logic [XLEN-1:0]  fetch_addr_o,
    output logic [TAG_W-1:0] fetch_tag_o,
    input  logic             rsp_valid_i,
    input  logic [XLEN-1:0]  rsp_data_i,
    input  logic [TAG_W-1:0] rsp_tag_i,
    input  logic             cond_known_i,
    input  logic             cond_taken_i,
    output logic             issue_valid_o,
    input  logic             issue_ready_i,
    output logic [XLEN-1:0]  issue_instr_o,
    output logic [XLEN-1:0]  issue_pc_o,
    output logic             issue_pred_o,
    input  logic             redirect_valid_i,
    input  logic [XLEN-1:0]  redirect_pc_i
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] occupancy;
    logic [CNT_W-1:0] inflight;
    logic [XLEN-1:0]  resp_pc;
    logic             rsp_accept;
    logic             scan_keep, scan_pred, scan_redir;
    logic [XLEN-1:0]  scan_target;
    logic             redir;
    logic [XLEN-1:0]  redir_pc;
    logic             push, pop, head_valid;
    slot_t            push_slot, head_slot;

    // stale path words are dropped; a flush cycle accepts nothing
    assign rsp_accept = rsp_valid_i && (rsp_tag_i == fetch_tag_o) && !redirect_valid_i;

    lfb_branch_scan u_scan (
        .word_i        (rsp_data_i),
        .pc_i          (resp_pc),
        .cond_known_i  (cond_known_i),
        .cond_taken_i  (cond_taken_i),
        .keep_o        (scan_keep),
        .pred_taken_o  (scan_pred),
        .redirect_o    (scan_redir),
        .redirect_pc_o (scan_target)
    );

    assign push      = rsp_accept && scan_keep;
    assign push_slot = '{pc: resp_pc, instr: rsp_data_i, pred_taken: scan_pred};
    assign redir     = redirect_valid_i || (rsp_accept && scan_redir);
    assign redir_pc  = redirect_valid_i ? redirect_pc_i : scan_target;

    lfb_fetch_ctl #(
        .DEPTH    (DEPTH),
        .TAG_W    (TAG_W),
        .RESET_PC (RESET_PC)
    ) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .occupancy_i  (occupancy),
        .redir_i      (redir),
        .redir_pc_i   (redir_pc),
        .rsp_valid_i  (rsp_valid_i),
        .rsp_accept_i (rsp_accept),
        .fetch_req_o  (fetch_req_o),
        .fetch_addr_o (fetch_addr_o),
        .fetch_tag_o  (fetch_tag_o),
        .resp_pc_o    (resp_pc),
        .inflight_o   (inflight)
    );

    lfb_slot_queue #(
        .DEPTH (DEPTH)
    ) u_queue (
        .clk          (clk),
        .rst          (rst),
        .flush_i      (redirect_valid_i),
        .push_i       (push),
        .push_data_i  (push_slot),
        .pop_i        (pop),
        .head_o       (head_slot),
        .head_valid_o (head_valid),
        .count_o      (occupancy)
    );

    assign issue_valid_o = head_valid && !redirect_valid_i;
    assign pop           = issue_valid_o && issue_ready_i;
    assign issue_instr_o = head_slot.instr;
    assign issue_pc_o    = head_slot.pc;
    assign issue_pred_o  = head_slot.pred_taken;

endmodule

// File: rtl/lfb_checker.sv
module lfb_checker
    import lfb_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int TAG_W = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       fetch_req_o,
    input logic [XLEN-1:0]            fetch_addr_o,
    input logic [TAG_W-1:0]           fetch_tag_o,
    input logic                       rsp_valid_i,
    input logic [TAG_W-1:0]           rsp_tag_i,
    input logic                       issue_valid_o,
    input logic                       issue_ready_i,
    input logic [XLEN-1:0]            issue_instr_o,
    input logic [XLEN-1:0]            issue_pc_o,
    input logic                       issue_pred_o,
    input logic                       redirect_valid_i,
    input logic [XLEN-1:0]            redirect_pc_i,
    input logic [$clog2(DEPTH+1)-1:0] occupancy,
    input logic [$clog2(DEPTH+1)-1:0] inflight
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W:0] committed;
    assign committed = {1'b0, occupancy} + {1'b0, inflight};

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (occupancy == '0 && inflight == '0 && fetch_tag_o == '0));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        committed <= (CNT_W + 1)'(DEPTH));

    assert_fetch_gate_R2: assert property (@(posedge clk) disable iff (rst)
        fetch_req_o |-> committed < (CNT_W + 1)'(DEPTH));

    assert_no_jump_issued_R5: assert property (@(posedge clk) disable iff (rst)
        issue_valid_o |-> issue_instr_o[31:26] != OPC_JUMP);

    assert_pred_sign_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_o && issue_instr_o[31:26] == OPC_BCOND) |-> issue_pred_o == issue_instr_o[25]);

    assert_hold_offer_R8: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_o && !issue_ready_i) |=>
            (redirect_valid_i || (issue_valid_o && $stable(issue_pc_o) && $stable(issue_instr_o))));

    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (rst)
        redirect_valid_i |=> occupancy == '0);

    assert_flush_addr_R9: assert property (@(posedge clk) disable iff (rst)
        redirect_valid_i |=> fetch_addr_o == $past(redirect_pc_i));

    assert_stale_dropped_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_i && rsp_tag_i != fetch_tag_o) |=> occupancy <= $past(occupancy));

    assert_tag_moves_R11: assert property (@(posedge clk) disable iff (rst)
        redirect_valid_i |=> fetch_tag_o != $past(fetch_tag_o));

endmodule

bind lookahead_fetch_buffer lfb_checker #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W)
) u_lfb_checker (
    .clk              (clk),
    .rst              (rst),
    .fetch_req_o      (fetch_req_o),
    .fetch_addr_o     (fetch_addr_o),
    .fetch_tag_o      (fetch_tag_o),
    .rsp_valid_i      (rsp_valid_i),
    .rsp_tag_i        (rsp_tag_i),
    .issue_valid_o    (issue_valid_o),
    .issue_ready_i    (issue_ready_i),
    .issue_instr_o    (issue_instr_o),
    .issue_pc_o       (issue_pc_o),
    .issue_pred_o     (issue_pred_o),
    .redirect_valid_i (redirect_valid_i),
    .redirect_pc_i    (redirect_pc_i),
    .occupancy        (occupancy),
    .inflight         (inflight)
);

// File: tb/lookahead_fetch_buffer_tb.sv
module lookahead_fetch_buffer_tb;
    import lfb_pkg::*;

    localparam int TAG_W     = 3;
    localparam int N_ISSUE   = 40;
    localparam int FLUSH_AT  = 15;
    localparam logic [31:0] FLUSH_PC = 32'd48;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fetch_req_o;
    logic [31:0]      fetch_addr_o;
    logic [TAG_W-1:0] fetch_tag_o;
    logic             rsp_valid_i = 1'b0;
    logic [31:0]      rsp_data_i = '0;
    logic [TAG_W-1:0] rsp_tag_i = '0;
    logic             cond_known_i = 1'b0;
    logic             cond_taken_i = 1'b0;
    logic             issue_valid_o;
    logic             issue_ready_i = 1'b0;
    logic [31:0]      issue_instr_o;
    logic [31:0]      issue_pc_o;
    logic             issue_pred_o;
    logic             redirect_valid_i = 1'b0;
    logic [31:0]      redirect_pc_i = '0;

    always #10 clk = ~clk;

    lookahead_fetch_buffer #(.DEPTH(6), .TAG_W(TAG_W), .RESET_PC('0)) u_dut (
        .clk(clk), .rst(rst),
        .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o), .fetch_tag_o(fetch_tag_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .rsp_tag_i(rsp_tag_i),
        .cond_known_i(cond_known_i), .cond_taken_i(cond_taken_i),
        .issue_valid_o(issue_valid_o), .issue_ready_i(issue_ready_i),
        .issue_instr_o(issue_instr_o), .issue_pc_o(issue_pc_o), .issue_pred_o(issue_pred_o),
        .redirect_valid_i(redirect_valid_i), .redirect_pc_i(redirect_pc_i)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // memory pipeline model (in-order, fixed latency)
    logic             pv [4];
    logic [31:0]      pa [4];
    logic [TAG_W-1:0] pt [4];
    logic [7:0]       lfsr;
    logic [31:0]      exp_pc;

    // Program: word 2 jump +3, word 6 forward cond +4, word 11 backward cond -4,
    // word 20 jump -20, all others plain words carrying their index
    function automatic logic [31:0] prog_word(input logic [31:0] addr);
        logic [29:0] idx;
        idx = addr[31:2];
        case (idx)
            30'd2:   return {OPC_JUMP,  26'd3};
            30'd6:   return {OPC_BCOND, 26'd4};
            30'd11:  return {OPC_BCOND, 26'h3FFFFFC};
            30'd20:  return {OPC_JUMP,  26'h3FFFFEC};
            default: return {6'h01, idx[25:0]};
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // reference walk of the program from the requirements
    task automatic exp_next(output logic [31:0] epc, output logic [31:0] ew, output logic ep);
        logic [31:0] w, tgt;
        bit          done;
        done = 0;
        epc = '0; ew = '0; ep = 1'b0;
        for (int k = 0; k < 64 && !done; k++) begin
            w   = prog_word(exp_pc);
            tgt = exp_pc + {{4{w[25]}}, w[25:0], 2'b00};
            if (w[31:26] == OPC_JUMP) begin
                exp_pc = tgt;
            end else if (w[31:26] == OPC_BCOND && cond_known_i) begin
                exp_pc = cond_taken_i ? tgt : exp_pc + 32'd4;
            end else if (w[31:26] == OPC_BCOND) begin
                epc = exp_pc; ew = w; ep = w[25];
                exp_pc = w[25] ? tgt : exp_pc + 32'd4;
                done = 1;
            end else begin
                epc = exp_pc; ew = w; ep = 1'b0;
                exp_pc = exp_pc + 32'd4;
                done = 1;
            end
        end
    endtask

    function automatic logic ready_pattern(input int mode, input int cyc, input logic [7:0] r);
        case (mode)
            0:       return 1'b1;
            1:       return cyc[0];
            2:       return r[0];
            default: return (cyc >= 40);
        endcase
    endfunction

    task automatic run(input int lat, input int mode, input logic ck, input logic ct);
        int          issued, cyc;
        bit          flushed, after_flush, first_after, hold_prev;
        logic [31:0] hold_pc, epc, ew;
        logic [TAG_W-1:0] tag_before;
        logic        ep;
        cond_known_i = ck;
        cond_taken_i = ct;
        @(negedge clk);
        rst = 1'b1;
        rsp_valid_i = 1'b0;
        redirect_valid_i = 1'b0;
        issue_ready_i = 1'b0;
        for (int k = 0; k < 4; k++) begin pv[k] = 1'b0; pa[k] = '0; pt[k] = '0; end
        lfsr = 8'hA5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: state right after reset
        check(issue_valid_o == 1'b0, "R1", "issue_valid after reset", 32'(issue_valid_o), 32'd0);
        check(fetch_req_o == 1'b1, "R1", "fetch_req after reset", 32'(fetch_req_o), 32'd1);
        check(fetch_addr_o == 32'd0, "R1", "fetch_addr after reset", fetch_addr_o, 32'd0);
        check(fetch_tag_o == '0, "R1", "fetch_tag after reset", 32'(fetch_tag_o), 32'd0);
        exp_pc = '0;
        issued = 0; cyc = 0;
        flushed = 0; after_flush = 0; first_after = 0; hold_prev = 0;
        hold_pc = '0; tag_before = '0;
        while (issued < N_ISSUE && cyc < 600) begin
            rsp_valid_i = pv[lat-1];
            rsp_data_i  = prog_word(pa[lat-1]);
            rsp_tag_i   = pt[lat-1];
            for (int k = 3; k > 0; k--) begin pv[k] = pv[k-1]; pa[k] = pa[k-1]; pt[k] = pt[k-1]; end
            issue_ready_i    = ready_pattern(mode, cyc, lfsr);
            lfsr             = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            redirect_valid_i = (issued == FLUSH_AT) && !flushed;
            redirect_pc_i    = FLUSH_PC;
            #1;
            if (after_flush) begin
                // R9 / R11: fetch restarts at the corrected address on a new tag
                check(fetch_addr_o == FLUSH_PC, "R9", "fetch_addr after redirect", fetch_addr_o, FLUSH_PC);
                check(fetch_tag_o != tag_before, "R11", "tag after redirect", 32'(fetch_tag_o), 32'(tag_before));
                after_flush = 0;
            end
            if (redirect_valid_i) begin
                check(issue_valid_o == 1'b0, "R9", "issue during redirect", 32'(issue_valid_o), 32'd0);
                flushed = 1; after_flush = 1; first_after = 1;
                tag_before = fetch_tag_o;
                exp_pc = FLUSH_PC;
                hold_prev = 0;
            end
            if (mode == 3 && cyc == 39) begin
                // R2: decode stalled long enough to fill every slot
                check(fetch_req_o == 1'b0, "R2", "fetch_req with full buffer", 32'(fetch_req_o), 32'd0);
                check(issue_valid_o == 1'b1, "R2", "offer with full buffer", 32'(issue_valid_o), 32'd1);
            end
            if (hold_prev && issue_valid_o) begin
                check(issue_pc_o == hold_pc, "R8", "held offer pc", issue_pc_o, hold_pc);
            end
            hold_prev = issue_valid_o && !issue_ready_i;
            hold_pc   = issue_pc_o;
            pv[0] = fetch_req_o; pa[0] = fetch_addr_o; pt[0] = fetch_tag_o;
            if (issue_valid_o && issue_ready_i) begin
                exp_next(epc, ew, ep);
                if (first_after) begin
                    // R10: stale words in flight never reach decode
                    check(issue_pc_o == FLUSH_PC, "R10", "first pc after flush", issue_pc_o, FLUSH_PC);
                    first_after = 0;
                end
                check(issue_pc_o == epc, "R3", "issue pc", issue_pc_o, epc);
                check(issue_instr_o == ew, "R4", "issue word", issue_instr_o, ew);
                check(issue_pred_o == ep, "R7", "prediction", 32'(issue_pred_o), 32'(ep));
                check(issue_instr_o[31:26] != OPC_JUMP, "R5", "jump issued", issue_instr_o, 32'd0);
                if (ck) check(issue_instr_o[31:26] != OPC_BCOND, "R6", "resolved branch issued",
                              issue_instr_o, 32'd0);
                issued++;
            end
            cyc++;
            @(negedge clk);
        end
        check(issued >= N_ISSUE, "R3", "words issued in run", 32'(issued), 32'(N_ISSUE));
        redirect_valid_i = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL R3 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int lat = 1; lat <= 3; lat++) begin
            for (int mode = 0; mode < 4; mode++) begin
                for (int cm = 0; cm < 3; cm++) begin
                    run(lat, mode, cm != 0, cm == 2);
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule